// File: doc/BRIEF.md
# Soft-Stepping Digital Volume Control

This block is the gain stage of a single audio channel. The host sets a target level as an 8-bit signed code and may also request mute. The block does not jump to the new level. It walks its applied gain toward the target in 0.125 dB increments, one increment for each sample strobe. Ramping the gain this way keeps zipper noise and clicks out of the audio. A slow setting halves the ramp rate. A bypass setting makes the gain land on the target at the next strobe.

The applied gain is available as a signed index in eighth-decibel units. A flag goes high once that index equals the requested level, so the host knows when a ramp has finished. This matters most before a clock or rate change, when the host needs to know the channel is fully muted. Each strobed input sample is scaled by the gain that was applied when the strobe arrived. The result saturates to the sample width.

Top module: `sstep_vol`

## Requirements
- R1: `tgt_code` is two's complement in 0.5 dB units, and the requested level in 0.125 dB units is 4 × code. Codes above +48 are treated as +48, giving level 192. Code -128 is treated as -127, giving level -508.
- R2: With `step_bypass` low and `slow_rate` low, each `sample_stb` moves `gain_idx` by exactly one unit toward the requested level. `gain_idx` does not move when it already equals that level.
- R3: With `slow_rate` high, a one-unit step happens only on the 2nd, 4th, 6th, … strobe counted since reset. Other strobes leave `gain_idx` unchanged.
- R4: With `step_bypass` high, a strobe loads the requested level into `gain_idx` directly.
- R5: While `mute_req` is high, the requested level is -512, a mute floor below -63.5 dB. The gain ramps to that floor under the same rate rules.
- R6: `gain_at_target` is high exactly when `gain_idx` equals the requested level, in the same cycle.
- R7: Without a strobe, `gain_idx` keeps its value whatever the control inputs do.
- R8: After reset, `gain_idx` is -512 and `sample_out` is 0.
- R9: On a strobe, `sample_out` becomes floor(`sample_in` × 2^(L/48)), where L is `gain_idx` just before that strobe. The result is accurate to within 2 LSB plus 0.05 %. When L is -512, the result is exactly 0.
- R10: A scaled value beyond the signed range of `SAMPLE_W` bits clips to the largest or the smallest representable value.
- R11: Without a strobe, `sample_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_code | input | 8 | Signed target volume, 0.5 dB per LSB |
| mute_req | input | 1 | Ramp toward the mute floor |
| slow_rate | input | 1 | One step per two strobes |
| step_bypass | input | 1 | Load the target without ramping |
| sample_stb | input | 1 | One-cycle pulse per audio sample |
| sample_in | input | SAMPLE_W | Signed input sample |
| gain_idx | output | 10 | Applied gain, signed, 0.125 dB per LSB |
| gain_at_target | output | 1 | Applied gain equals requested level |
| sample_out | output | SAMPLE_W | Scaled, saturated sample |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Off-by-one at the ramp end.** A design with this fault overshoots the target or oscillates around it, so the done flag flickers instead of settling.
- **Wrong strobe parity in slow mode.** The first step then lands one sample early.
- **Out-of-range codes.** A design that fails to clamp +49…+127 or -128 wraps the gain.
- **Mute ramp end point.** A design that stops at -508 never raises the done flag under mute and leaks audio.
- **Full-scale samples at +24 dB.** These catch a scaler that wraps instead of clipping.
- **Sample scaling timing.** These checks show whether the scaler used the gain in force before or after the strobe's step.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

   // gain is kept in eighth-decibel units; 48 units are taken as one octave
   localparam int unsigned FRAC_PER_CODE = 4;
   localparam int unsigned OCT_UNITS     = 48;
   localparam int unsigned SUB_UNITS     = 6;    // units per coarse table entry
   localparam int unsigned BIAS_OCT      = 11;   // octaves added to make the index non-negative
   localparam int unsigned TBL_FRAC      = 14;   // fraction bits of both tables
   localparam int unsigned GAIN_W        = 10;

   typedef logic signed [GAIN_W-1:0] gain_t;

   // 2^(a/8), a = 0..7, scaled by 2^14
   function automatic logic [15:0] coarse_mul(input logic [2:0] a);
      case (a)
         3'd0: coarse_mul = 16'd16384;
         3'd1: coarse_mul = 16'd17867;
         3'd2: coarse_mul = 16'd19484;
         3'd3: coarse_mul = 16'd21247;
         3'd4: coarse_mul = 16'd23170;
         3'd5: coarse_mul = 16'd25268;
         3'd6: coarse_mul = 16'd27554;
         default: coarse_mul = 16'd30048;
      endcase
   endfunction

   // 2^(b/48), b = 0..5, scaled by 2^14
   function automatic logic [15:0] fine_mul(input logic [2:0] b);
      case (b)
         3'd0: fine_mul = 16'd16384;
         3'd1: fine_mul = 16'd16622;
         3'd2: fine_mul = 16'd16864;
         3'd3: fine_mul = 16'd17109;
         3'd4: fine_mul = 16'd17358;
         default: fine_mul = 16'd17611;
      endcase
   endfunction

endpackage

// File: rtl/sstep_target.sv
module sstep_target
   import sstep_pkg::*;
#(
   parameter int MAX_CODE = 48,
   parameter int MIN_CODE = -127
) (
   input  logic signed [7:0] code,
   input  logic              mute,
   output gain_t             level
);
   localparam int MUTE_LVL = (MIN_CODE - 1) * int'(FRAC_PER_CODE);

   always_comb begin
      if (mute)
         level = gain_t'(MUTE_LVL);
      else if (int'(code) > MAX_CODE)
         level = gain_t'(MAX_CODE * int'(FRAC_PER_CODE));
      else if (int'(code) < MIN_CODE)
         level = gain_t'(MIN_CODE * int'(FRAC_PER_CODE));
      else
         level = gain_t'(int'(code) * int'(FRAC_PER_CODE));
   end

endmodule

// File: rtl/sstep_ramp.sv
module sstep_ramp
   import sstep_pkg::*;
#(
   parameter int MUTE_LVL = -512
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  stb,
   input  logic  slow,
   input  logic  bypass,
   input  gain_t target,
   output gain_t level
);
   logic odd_q;
   logic step_ok;

   assign step_ok = !slow || odd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= gain_t'(MUTE_LVL);
         odd_q <= 1'b0;
      end else if (stb) begin
         odd_q <= ~odd_q;
         if (bypass)
            level <= target;
         else if (step_ok && (level < target))
            level <= level + gain_t'(1);
         else if (step_ok && (level > target))
            level <= level - gain_t'(1);
      end
   end

endmodule

// File: rtl/sstep_scale.sv
module sstep_scale
   import sstep_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int MUTE_LVL = -512
) (
   input  gain_t                      level,
   input  logic signed [SAMPLE_W-1:0] din,
   output logic signed [SAMPLE_W-1:0] dout
);
   localparam int BIAS_UNITS = int'(BIAS_OCT * OCT_UNITS);
   localparam int BASE_SH    = int'(2 * TBL_FRAC + BIAS_OCT);
   localparam logic signed [63:0] POS_LIM = (64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1;
   localparam logic signed [63:0] NEG_LIM = -(64'sd1 <<< (SAMPLE_W - 1));

   logic signed [11:0] biased;
   logic        [10:0] idx;
   logic        [3:0]  oct;
   logic        [5:0]  rem;
   logic        [2:0]  sel_c, sel_f;
   logic        [5:0]  shamt;
   logic signed [63:0] xs, cs, fs, prod, shifted;

   always_comb begin
      biased  = 12'(level) + 12'(BIAS_UNITS);
      idx     = biased[10:0];
      oct     = 4'(idx / 11'(OCT_UNITS));
      rem     = 6'(idx % 11'(OCT_UNITS));
      sel_c   = 3'(rem / 6'(SUB_UNITS));
      sel_f   = 3'(rem % 6'(SUB_UNITS));
      shamt   = 6'(BASE_SH) - {2'b00, oct};
      xs      = {{(64-SAMPLE_W){din[SAMPLE_W-1]}}, din};
      cs      = {48'd0, coarse_mul(sel_c)};
      fs      = {48'd0, fine_mul(sel_f)};
      prod    = xs * cs * fs;
      shifted = prod >>> shamt;
      if (level == gain_t'(MUTE_LVL))
         dout = '0;
      else if (shifted > POS_LIM)
         dout = POS_LIM[SAMPLE_W-1:0];
      else if (shifted < NEG_LIM)
         dout = NEG_LIM[SAMPLE_W-1:0];
      else
         dout = shifted[SAMPLE_W-1:0];
   end

endmodule

// File: rtl/sstep_vol.sv
module sstep_vol
   import sstep_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int MAX_CODE = 48,
   parameter int MIN_CODE = -127,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic signed [7:0]          tgt_code,
   input  logic                       mute_req,
   input  logic                       slow_rate,
   input  logic                       step_bypass,
   input  logic                       sample_stb,
   input  logic signed [SAMPLE_W-1:0] sample_in,
   output logic signed [9:0]          gain_idx,
   output logic                       gain_at_target,
   output logic signed [SAMPLE_W-1:0] sample_out
);
   localparam int MUTE_LVL = (MIN_CODE - 1) * int'(FRAC_PER_CODE);

   if (SAMPLE_W < 8 || SAMPLE_W > 28) begin : g_bad_width
      $error("sstep_vol: SAMPLE_W must lie in 8..28");
   end
   if (MAX_CODE > 48 || MIN_CODE < -127 || MIN_CODE >= MAX_CODE) begin : g_bad_range
      $error("sstep_vol: code range exceeds the gain index or scaler span");
   end

   gain_t                      req_lvl;
   gain_t                      cur_lvl;
   logic signed [SAMPLE_W-1:0] scaled;

   sstep_target #(.MAX_CODE(MAX_CODE), .MIN_CODE(MIN_CODE)) u_target (
      .code  (tgt_code),
      .mute  (mute_req),
      .level (req_lvl)
   );

   sstep_ramp #(.MUTE_LVL(MUTE_LVL)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (sample_stb),
      .slow   (slow_rate),
      .bypass (step_bypass),
      .target (req_lvl),
      .level  (cur_lvl)
   );

   sstep_scale #(.SAMPLE_W(SAMPLE_W), .MUTE_LVL(MUTE_LVL)) u_scale (
      .level (cur_lvl),
      .din   (sample_in),
      .dout  (scaled)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sample_out <= '0;
         else if (sample_stb)
            sample_out <= scaled;
      end
   end else begin : g_out_comb
      assign sample_out = scaled;
   end

   assign gain_idx       = cur_lvl;
   assign gain_at_target = (cur_lvl == req_lvl);

endmodule

// File: rtl/sstep_vol_chk.sv
module sstep_vol_chk #(
   parameter int SAMPLE_W = 24,
   parameter bit OUT_REG  = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic signed [7:0]          tgt_code,
   input logic                       mute_req,
   input logic                       step_bypass,
   input logic                       sample_stb,
   input logic signed [9:0]          gain_idx,
   input logic                       gain_at_target,
   input logic signed [SAMPLE_W-1:0] sample_out
);

   // R1 / R5: applied gain never leaves the mute floor .. +24 dB span
   p_gain_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_idx >= -10'sd512) && (gain_idx <= 10'sd192));

   // R2: a ramping strobe moves the gain by at most one unit
   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && !step_bypass) |=>
      ((gain_idx - $past(gain_idx) <= 10'sd1) && ($past(gain_idx) - gain_idx <= 10'sd1)));

   // R7: no strobe, no gain change
   p_hold_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(gain_idx));

   // R4 / R6: bypass lands on the request unless the request moved
   p_bypass_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && step_bypass) |=>
      (gain_at_target || !$stable(tgt_code) || !$stable(mute_req)));

   if (OUT_REG) begin : g_out_checks
      // R11: output held between strobes
      p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !sample_stb |=> $stable(sample_out));
      // R9: at the mute floor the strobed sample is silent
      p_mute_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (sample_stb && gain_idx == -10'sd512) |=> (sample_out == '0));
   end

endmodule

bind sstep_vol sstep_vol_chk #(.SAMPLE_W(SAMPLE_W), .OUT_REG(OUT_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tgt_code       (tgt_code),
   .mute_req       (mute_req),
   .step_bypass    (step_bypass),
   .sample_stb     (sample_stb),
   .gain_idx       (gain_idx),
   .gain_at_target (gain_at_target),
   .sample_out     (sample_out)
);

// File: tb/test_sstep_vol.sv
module test_sstep_vol;
   localparam int SW = 24;
   localparam longint POS_MAX = (64'sd1 <<< (SW - 1)) - 1;
   localparam longint NEG_MAX = -(64'sd1 <<< (SW - 1));

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic signed [7:0]    tgt_code = '0;
   logic                 mute_req = 1'b0;
   logic                 slow_rate = 1'b0;
   logic                 step_bypass = 1'b0;
   logic                 sample_stb = 1'b0;
   logic signed [SW-1:0] sample_in = '0;
   logic signed [9:0]    gain_idx;
   logic                 gain_at_target;
   logic signed [SW-1:0] sample_out;

   int n_checks = 0;
   int n_fail = 0;
   int m_lvl = -512;
   bit m_odd = 1'b0;
   longint m_out = 0;

   always #5 clk = ~clk;

   sstep_vol #(.SAMPLE_W(SW)) i_sstep_vol (
      .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .mute_req(mute_req),
      .slow_rate(slow_rate), .step_bypass(step_bypass), .sample_stb(sample_stb),
      .sample_in(sample_in), .gain_idx(gain_idx), .gain_at_target(gain_at_target),
      .sample_out(sample_out)
   );

   function automatic int req_level(input int code, input bit mute);
      if (mute) return -512;
      if (code > 48) return 192;
      if (code < -127) return -508;
      return code * 4;
   endfunction

   function automatic longint scale_ref(input longint x, input int lvl);
      real v;
      if (lvl == -512) return 0;
      v = real'(x) * (2.0 ** (real'(lvl) / 48.0));
      if (v > real'(POS_MAX)) return POS_MAX;
      if (v < real'(NEG_MAX)) return NEG_MAX;
      return longint'(v);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_out(input string req);
      longint act = longint'(sample_out);
      longint d = act - m_out;
      longint tol = 2 + ((m_out < 0 ? -m_out : m_out) / 2000);
      check((d <= tol) && (d >= -tol), req, act, m_out);
   endtask

   // one strobe: set sample, pulse, update model, check state after the edge
   task automatic strobe(input longint x, input string req);
      int tgt;
      @(negedge clk);
      sample_in = x[SW-1:0];
      sample_stb = 1'b1;
      tgt = req_level(int'(tgt_code), mute_req);
      m_out = scale_ref(longint'(sample_in), m_lvl);
      if (step_bypass) m_lvl = tgt;
      else if (!slow_rate || m_odd) begin
         if (m_lvl < tgt) m_lvl++;
         else if (m_lvl > tgt) m_lvl--;
      end
      m_odd = ~m_odd;
      @(negedge clk);
      sample_stb = 1'b0;
      check(int'(gain_idx) == m_lvl, req, longint'(gain_idx), longint'(m_lvl));
      check(gain_at_target == (m_lvl == req_level(int'(tgt_code), mute_req)), "R6",
            longint'(gain_at_target), longint'(m_lvl == req_level(int'(tgt_code), mute_req)));
      check_out("R9");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R8 reset state
      check(int'(gain_idx) == -512, "R8", longint'(gain_idx), -512);
      check(sample_out == '0, "R8", longint'(sample_out), 0);
      check(gain_at_target == 1'b0, "R6", longint'(gain_at_target), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 bypass to 0 dB
      step_bypass = 1'b1; tgt_code = 8'sd0;
      strobe(1000, "R4");
      step_bypass = 1'b0;

      // R2 ramp up 2 dB: 16 unit steps, done flag only at the end
      tgt_code = 8'sd4;
      for (int i = 0; i < 16; i++) strobe(longint'(i * 1000), "R2");
      check(int'(gain_idx) == 16, "R2", longint'(gain_idx), 16);

      // R7 no strobe: gain holds while controls change; R11 output holds
      tgt_code = -8'sd10; sample_in = 24'sd5555;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(int'(gain_idx) == 16, "R7", longint'(gain_idx), 16);
         check_out("R11");
      end

      // R3 slow ramp down
      slow_rate = 1'b1;
      for (int i = 0; i < 12; i++) strobe(-20000, "R3");
      slow_rate = 1'b0;

      // R1 clamps
      step_bypass = 1'b1;
      tgt_code = 8'sd100;
      strobe(100, "R1");
      check(int'(gain_idx) == 192, "R1", longint'(gain_idx), 192);
      tgt_code = -8'sd128;
      strobe(100, "R1");
      check(int'(gain_idx) == -508, "R1", longint'(gain_idx), -508);
      step_bypass = 1'b0;

      // R5 mute ramp to the floor, then silence
      mute_req = 1'b1;
      for (int i = 0; i < 4; i++) strobe(300000, "R5");
      check(int'(gain_idx) == -512 && gain_at_target, "R5", longint'(gain_idx), -512);
      strobe(4000000, "R9");
      check(sample_out == '0, "R9", longint'(sample_out), 0);
      mute_req = 1'b0;

      // R10 saturation at +24 dB
      step_bypass = 1'b1; tgt_code = 8'sd48;
      strobe(POS_MAX, "R10");
      strobe(POS_MAX, "R10");
      check(longint'(sample_out) == POS_MAX, "R10", longint'(sample_out), POS_MAX);
      strobe(NEG_MAX, "R10");
      check(longint'(sample_out) == NEG_MAX, "R10", longint'(sample_out), NEG_MAX);
      step_bypass = 1'b0;

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int r = int'($urandom_range(0, 99));
         if (r < 10) tgt_code = 8'($urandom);
         else if (r < 25) tgt_code = 8'(int'($urandom_range(0, 120)) - 80);
         mute_req    = ($urandom_range(0, 19) == 0);
         slow_rate   = ($urandom_range(0, 3) == 0);
         step_bypass = ($urandom_range(0, 29) == 0);
         strobe(longint'($signed(SW'($urandom))), "R2");
         if ($urandom_range(0, 3) == 0) begin
            @(negedge clk);
            check(int'(gain_idx) == m_lvl, "R7", longint'(gain_idx), longint'(m_lvl));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule